// File: doc/BRIEF.md
# Double-Buffered Sixteen-Channel DAC Register Front End

This block holds the digital codes for a bank of sixteen 8-bit DAC channels that a microprocessor loads over a parallel bus. Every channel has two register stages. A staging register takes bus data. A DAC register behind it drives the converter code. The host can stage codes one channel at a time and then move all of them into the DAC registers with one transfer strobe. Several DAC outputs therefore change together. The host can also read any staging register back over the same data bus.

All bus controls are active low: chip select, strobe, transfer, and a read/not-write line that is high for a read. They arrive asynchronously to the system clock. The address and data inputs pass through the same two-stage synchroniser as the controls, so all of them stay aligned. The sampled levels then drive clocked registers that stand in for level-sensitive latches. The bidirectional data bus is split into an input, an output and an output enable for the pad. The enable is dropped at once, without waiting for a clock edge, when chip select goes high or the read/not-write line goes low.

Top module: `dacbank_if`

## Requirements
- R1: After synchronous reset, all sixteen staging registers and all sixteen DAC registers hold 0x00, and `bus_oe` is low.
- R2: A write is active while `sel_n`, `stb_n` and `rnw` are all low. While it is active, the staging register selected by `ch_addr` follows `bus_i`, and no other staging register changes. A level applied at the pins affects the registers at the third rising clock edge after it is applied.
- R3: Written data is final once `stb_n` or `sel_n` goes high, whichever comes first. Later changes on `bus_i` or `ch_addr` do not change that staging register.
- R4: With `sel_n` and `rnw` held low, toggling `stb_n` with a new `ch_addr` and data on each low phase loads each of the sixteen channels with its own value.
- R5: While `xfer_n` and `stb_n` are both low, every DAC register takes the value of its staging register in the same cycle. At all other times the DAC registers do not change.
- R6: When `sel_n`, `stb_n`, `rnw` and `xfer_n` are all low together, the addressed DAC register follows `bus_i` in the same cycle as its staging register.
- R7: A read is active when `sel_n` is low, `rnw` is high, and `stb_n` and `xfer_n` are both high. During a read, `bus_oe` is high and `bus_o` carries the staging register selected by `ch_addr`. With `xfer_n` low, or at any other time, `bus_oe` stays low.
- R8: `bus_oe` is low whenever `sel_n` is high or `rnw` is low. This follows the pin level with no clock delay.
- R9: Writing one channel and then issuing a transfer changes only that channel's DAC register when the other channels' staging and DAC registers already match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| stb_n | input | 1 | Enable/strobe, active low; its rising edge ends a write |
| rnw | input | 1 | High selects read, low selects write |
| xfer_n | input | 1 | Transfer strobe, active low; copies staging to DAC registers |
| ch_addr | input | 4 | Channel address |
| bus_i | input | 8 | Data bus input from the pad |
| bus_o | output | 8 | Readback data to the pad |
| bus_oe | output | 1 | Pad output enable; low means the bus floats |
| dac_q | output | 128 | Sixteen DAC register codes, channel n in bits 8n+7..8n |

## Verification
The hardest case to reach is a write that ends by chip select rising while the strobe is still low, followed by bus data that keeps changing. Only a later readback can show whether the staging register kept its value. The stimulus raises `sel_n` first, scrambles `bus_i`, and only then raises the strobe. A second case puts a fresh bus level into the DAC outputs within the synchroniser latency: all four controls are held low so that write and transfer overlap, and the stimulus steps the data twice. A cycle-level model, fed with the same pin history, is compared against the outputs on every clock.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    parameter int N_CH   = 16;
    parameter int DW     = 8;
    parameter int AW     = $clog2(N_CH);
    parameter int STAGES = 2;

    localparam int BANK_W = N_CH * DW;

    typedef struct packed {
        logic          sel_n;
        logic          stb_n;
        logic          rnw;
        logic          xfer_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_t;

    localparam int BUS_W = $bits(bus_t);

    localparam bus_t BUS_IDLE = '{sel_n: 1'b1, stb_n: 1'b1, rnw: 1'b1,
                                  xfer_n: 1'b1, addr: '0, data: '0};

    typedef struct packed {
        logic wr;
        logic ld;
        logic rd;
    } cmd_t;

    function automatic cmd_t decode(bus_t b);
        cmd_t c;
        c.wr = !b.sel_n && !b.stb_n && !b.rnw;
        c.ld = !b.xfer_n && !b.stb_n;
        c.rd = !b.sel_n && b.rnw && b.stb_n && b.xfer_n;
        return c;
    endfunction

endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
    parameter int             W       = 8,
    parameter int             DEPTH   = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/dacbank_regs.sv
module dacbank_regs
    import dacbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    output logic [BANK_W-1:0] in_flat,
    output logic [BANK_W-1:0] dac_flat
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [DW-1:0] stage_q;
        logic [DW-1:0] stage_d;
        logic [DW-1:0] code_q;
        logic          hit;

        assign hit = cmd.wr && (addr == AW'(ch));

        always_comb begin
            stage_d = stage_q;
            if (hit) stage_d = data;
        end

        always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= stage_d;
        end

        // transfer takes the next-state value so an overlapping write passes through
        always_ff @(posedge clk) begin
            if (rst)         code_q <= '0;
            else if (cmd.ld) code_q <= stage_d;
        end

        assign in_flat[ch*DW +: DW]  = stage_q;
        assign dac_flat[ch*DW +: DW] = code_q;
    end
endmodule

// File: rtl/dacbank_rdbk.sv
module dacbank_rdbk
    import dacbank_pkg::*;
(
    input  logic [BANK_W-1:0] in_flat,
    input  logic [AW-1:0]     addr,
    input  cmd_t              cmd,
    input  logic              sel_n_pin,
    input  logic              rnw_pin,
    output logic [DW-1:0]     rd_data,
    output logic              rd_oe
);
    logic [DW-1:0] lanes [N_CH];

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
        assign lanes[ch] = in_flat[ch*DW +: DW];
    end

    assign rd_data = lanes[addr];
    // raw pin gating releases the pad before the synchronised view catches up
    assign rd_oe   = cmd.rd && !sel_n_pin && rnw_pin;
endmodule

// File: rtl/dacbank_if.sv
module dacbank_if
    import dacbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              stb_n,
    input  logic              rnw,
    input  logic              xfer_n,
    input  logic [AW-1:0]     ch_addr,
    input  logic [DW-1:0]     bus_i,
    output logic [DW-1:0]     bus_o,
    output logic              bus_oe,
    output logic [BANK_W-1:0] dac_q
);
    bus_t              raw_bus;
    logic [BUS_W-1:0]  sync_q;
    bus_t              s_bus;
    cmd_t              cmd;
    logic [AW-1:0]     s_addr;
    logic [BANK_W-1:0] in_flat;

    always_comb begin
        raw_bus.sel_n  = sel_n;
        raw_bus.stb_n  = stb_n;
        raw_bus.rnw    = rnw;
        raw_bus.xfer_n = xfer_n;
        raw_bus.addr   = ch_addr;
        raw_bus.data   = bus_i;
    end

    dacbank_sync #(
        .W       (BUS_W),
        .DEPTH   (STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (sync_q)
    );

    assign s_bus  = bus_t'(sync_q);
    assign cmd    = decode(s_bus);
    assign s_addr = s_bus.addr;

    dacbank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr     (s_addr),
        .data     (s_bus.data),
        .in_flat  (in_flat),
        .dac_flat (dac_q)
    );

    dacbank_rdbk u_rdbk (
        .in_flat   (in_flat),
        .addr      (s_addr),
        .cmd       (cmd),
        .sel_n_pin (sel_n),
        .rnw_pin   (rnw),
        .rd_data   (bus_o),
        .rd_oe     (bus_oe)
    );
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk
    import dacbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              rnw,
    input logic              bus_oe,
    input logic [BANK_W-1:0] dac_q,
    input logic [BANK_W-1:0] in_flat,
    input cmd_t              cmd,
    input logic [AW-1:0]     s_addr
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) addr_q <= s_addr;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $fell(rst) |-> (dac_q == '0 && in_flat == '0 && !bus_oe));

    // R2
    a_r2_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd.wr |=> $stable(in_flat));

    // R5
    a_r5_dac_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd.ld |=> $stable(dac_q));

    // R6
    a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.ld) |=>
            (dac_q[addr_q*DW +: DW] == in_flat[addr_q*DW +: DW]));

    // R7
    a_r7_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> cmd.rd);

    // R8
    a_r8_float_on_desel: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> !bus_oe);

    // R8
    a_r8_no_drive_write: assert property (@(posedge clk) disable iff (rst)
        !rnw |-> !bus_oe);
endmodule

bind dacbank_if dacbank_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_n   (sel_n),
    .rnw     (rnw),
    .bus_oe  (bus_oe),
    .dac_q   (dac_q),
    .in_flat (in_flat),
    .cmd     (cmd),
    .s_addr  (s_addr)
);

// File: tb/dacbank_if_tb.sv
module dacbank_if_tb;
    import dacbank_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, stb_n = 1'b1, rnw = 1'b1, xfer_n = 1'b1;
    logic [AW-1:0] ch_addr = '0;
    logic [DW-1:0] bus_i = '0;
    logic [DW-1:0] bus_o;
    logic          bus_oe;
    logic [BANK_W-1:0] dac_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dacbank_if u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .stb_n(stb_n), .rnw(rnw),
        .xfer_n(xfer_n), .ch_addr(ch_addr), .bus_i(bus_i),
        .bus_o(bus_o), .bus_oe(bus_oe), .dac_q(dac_q)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [BANK_W-1:0] act, input logic [BANK_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference, compared every clock ----------------
    typedef struct {
        bit sel_n, stb_n, rnw, xfer_n;
        int addr;
        int data;
    } smp_t;

    int   m_in  [N_CH];
    int   m_dac [N_CH];
    smp_t h_new, h_old;

    function automatic smp_t idle_smp();
        smp_t s;
        s.sel_n = 1; s.stb_n = 1; s.rnw = 1; s.xfer_n = 1; s.addr = 0; s.data = 0;
        return s;
    endfunction

    function automatic smp_t pins_now();
        smp_t s;
        s.sel_n = sel_n; s.stb_n = stb_n; s.rnw = rnw; s.xfer_n = xfer_n;
        s.addr = int'(ch_addr); s.data = int'(bus_i);
        return s;
    endfunction

    always @(negedge clk) begin
        logic [BANK_W-1:0] exp_dac;
        bit exp_oe;
        if (rst) begin
            foreach (m_in[i]) begin m_in[i] = 0; m_dac[i] = 0; end
            h_new = idle_smp();
            h_old = idle_smp();
        end else begin
            if (!h_old.sel_n && !h_old.stb_n && !h_old.rnw) m_in[h_old.addr] = h_old.data;
            if (!h_old.xfer_n && !h_old.stb_n)
                foreach (m_dac[i]) m_dac[i] = m_in[i];
            h_old = h_new;
            h_new = pins_now();
        end
        foreach (m_dac[i]) exp_dac[i*DW +: DW] = DW'(m_dac[i]);
        exp_oe = !h_old.sel_n && h_old.rnw && h_old.stb_n && h_old.xfer_n
                 && !sel_n && rnw;
        if (!done) begin
            chk(dac_q == exp_dac, "R5 per-cycle DAC codes", dac_q, exp_dac);
            chk(bus_oe == exp_oe, "R7 per-cycle output enable",
                BANK_W'(bus_oe), BANK_W'(exp_oe));
            if (exp_oe)
                chk(bus_o == DW'(m_in[h_old.addr]), "R7 per-cycle readback",
                    BANK_W'(bus_o), BANK_W'(m_in[h_old.addr]));
        end
    end

    // ---------------- directed stimulus ----------------
    logic [DW-1:0] val [N_CH];

    function automatic logic [BANK_W-1:0] val_flat();
        logic [BANK_W-1:0] f;
        for (int i = 0; i < N_CH; i++) f[i*DW +: DW] = val[i];
        return f;
    endfunction

    task automatic nxt(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic do_load();
        sel_n = 1; stb_n = 0; xfer_n = 0; nxt(2);
        xfer_n = 1; stb_n = 1; nxt(4);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        foreach (val[i]) val[i] = '0;
        nxt(3);
        rst = 0;
        nxt(1);
        chk(dac_q == '0, "R1 DAC codes after reset", dac_q, '0);
        chk(!bus_oe, "R1 bus floats after reset", BANK_W'(bus_oe), '0);

        // R4 burst load of all channels with the strobe as write clock (R2)
        sel_n = 0; rnw = 0;
        for (int i = 0; i < N_CH; i++) begin
            stb_n = 0; ch_addr = AW'(i);
            bus_i = DW'((i * 37 + 11) & 8'hFF);
            val[i] = bus_i;
            nxt(2);
            chk(!bus_oe, "R8 no drive during write", BANK_W'(bus_oe), '0);
            stb_n = 1; nxt(2);
        end
        sel_n = 1; rnw = 1; nxt(4);
        chk(dac_q == '0, "R5 DAC unchanged before transfer", dac_q, '0);

        // R3 strobe ends the write, then data changes
        sel_n = 0; rnw = 0; ch_addr = 4'd3; bus_i = 8'h5C; stb_n = 0; nxt(2);
        stb_n = 1; nxt(1);
        bus_i = 8'hFF; nxt(3);
        val[3] = 8'h5C;
        // R3 chip select ends the write while strobe is still low
        ch_addr = 4'd9; bus_i = 8'h42; stb_n = 0; nxt(2);
        sel_n = 1; nxt(1);
        bus_i = 8'h00; ch_addr = 4'd2; nxt(3);
        stb_n = 1; rnw = 1; nxt(3);
        val[9] = 8'h42;

        do_load();
        chk(dac_q == val_flat(), "R5 transfer copies all channels", dac_q, val_flat());

        // R7 readback of every address
        sel_n = 0; rnw = 1; stb_n = 1; xfer_n = 1;
        for (int i = 0; i < N_CH; i++) begin
            ch_addr = AW'(i); nxt(3);
            chk(bus_oe, "R7 readback enables bus", BANK_W'(bus_oe), 1);
            chk(bus_o == val[i], "R7 readback value (R3/R4)", BANK_W'(bus_o), BANK_W'(val[i]));
        end
        sel_n = 1; #1;
        chk(!bus_oe, "R8 bus floats at once on deselect", BANK_W'(bus_oe), '0);
        nxt(3);
        chk(!bus_oe, "R8 bus stays floating", BANK_W'(bus_oe), '0);

        // R7 no read while transfer low
        sel_n = 0; xfer_n = 0; ch_addr = 4'd5; nxt(3);
        chk(!bus_oe, "R7 no drive with transfer low", BANK_W'(bus_oe), '0);
        xfer_n = 1; nxt(3);
        rnw = 0; #1;
        chk(!bus_oe, "R8 write direction releases bus", BANK_W'(bus_oe), '0);
        sel_n = 1; nxt(2);

        // R9 single channel update
        sel_n = 0; rnw = 0; ch_addr = 4'd12; bus_i = 8'h99; stb_n = 0; nxt(2);
        stb_n = 1; nxt(1); sel_n = 1; rnw = 1; nxt(2);
        val[12] = 8'h99;
        do_load();
        chk(dac_q == val_flat(), "R9 only channel 12 changes", dac_q, val_flat());

        // R6 transparent path through both stages
        sel_n = 0; rnw = 0; stb_n = 0; xfer_n = 0; ch_addr = 4'd7; bus_i = 8'h11;
        nxt(3);
        chk(dac_q[7*DW +: DW] == 8'h11, "R6 transparent first value",
            BANK_W'(dac_q[7*DW +: DW]), BANK_W'(8'h11));
        bus_i = 8'h22; nxt(3);
        val[7] = 8'h22;
        chk(dac_q == val_flat(), "R6 transparent follows bus", dac_q, val_flat());
        xfer_n = 1; stb_n = 1; sel_n = 1; rnw = 1; nxt(4);

        done = 1;
        summary();
        $finish;
    end
endmodule